// File: doc/BRIEF.md
# Code-Bag Descriptor Dispatcher

This block turns one packed descriptor word into a stream of instruction words. The descriptor holds a start address in its upper bits and a word count in its low bits. After it accepts a descriptor, the block reads the words at consecutive ascending addresses from a local synchronous-read memory. It sends each word downstream on a valid/ready channel, together with the address the word came from.

The memory is inside the block and has a separate write port, used to preload programs before dispatch. Reads take one cycle. The sequencer issues a read only when the output slot is free or is being emptied in the same cycle. As a result a stalled consumer never loses or repeats a word, and an unstalled consumer receives one word per cycle. The descriptor input accepts a new bag only when the block is idle. A one-cycle completion pulse marks the end of each non-empty bag.

Top module: `bag_dispatch`

## Requirements
- R1: The descriptor's low CNT_W bits (default 6, bits [5:0]) hold the word count, 0 to 63. The BASE_W bits above them (default 18, bits [23:6]) hold the start address.
- R2: A bag with base B and count N delivers exactly N words. Their ins_addr tags are B, B+1, ..., B+N-1, in that order.
- R3: Each delivered ins_word equals the value last written through the write port at that word's memory location.
- R4: A descriptor with count zero is accepted and delivers no word. It raises no bag_done, and desc_ready stays high.
- R5: desc_ready is low from the cycle after a non-empty descriptor is accepted until its last word is taken. A descriptor offered in that time is not accepted and produces no words.
- R6: While ins_valid is high and ins_ready is low, ins_valid, ins_word and ins_addr hold their values into the next cycle.
- R7: The address counter is BASE_W bits wide and wraps modulo 2^BASE_W. The memory location used is the address modulo 2^MEM_AW.
- R8: bag_done is high for exactly one cycle, the cycle after the last word of a non-empty bag is taken. desc_ready is high again in that same cycle.
- R9: While synchronous reset is applied, and in the cycle after it, ins_valid and bag_done are low and desc_ready is high. This holds even if reset arrives in the middle of a bag.
- R10: The first word is valid in the second cycle after the descriptor is accepted. With ins_ready held high, the following words arrive one per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| desc_valid | input | 1 | Descriptor offered |
| desc_ready | output | 1 | Block idle, descriptor can be taken |
| desc_word | input | BASE_W+CNT_W | Packed start address and word count |
| wr_en | input | 1 | Memory preload write strobe |
| wr_addr | input | MEM_AW | Memory preload location |
| wr_data | input | DATA_W | Memory preload data |
| ins_valid | output | 1 | Instruction word present |
| ins_ready | input | 1 | Consumer takes the word |
| ins_word | output | DATA_W | Fetched memory word |
| ins_addr | output | BASE_W | Address the word was read from |
| bag_done | output | 1 | One-cycle end-of-bag pulse |

## Verification
The bench applies irregular ready patterns. A sequencer that advanced its address during a stall would skip or repeat a tag, and the bench would see a broken address sequence. One bag crosses the memory's top location and another crosses the top of the 18-bit address space. A bad wrap would return wrong data or tags beyond the field width. The bench also runs a 63-word bag, a zero-count bag (which must neither emit nor signal done), a junk descriptor held valid during a busy bag (it must not start a second bag), and a reset in the middle of a bag (it must drop the pending word).

// File: rtl/bag_pkg.sv
package bag_pkg;

   typedef enum logic [1:0] {
      SEQ_IDLE  = 2'd0,
      SEQ_RUN   = 2'd1,
      SEQ_DRAIN = 2'd2
   } seq_state_t;

endpackage

// File: rtl/bag_desc_split.sv
module bag_desc_split #(
   parameter int CNT_W  = 6,
   parameter int BASE_W = 18,
   localparam int DESC_W = BASE_W + CNT_W
) (
   input  logic [DESC_W-1:0] desc,
   output logic [BASE_W-1:0] base,
   output logic [CNT_W-1:0]  count,
   output logic              empty
);

   if (CNT_W < 1 || CNT_W > 16) begin : g_bad_cnt
      $error("bag_desc_split: CNT_W out of range");
   end
   if (BASE_W < 1 || BASE_W > 32) begin : g_bad_base
      $error("bag_desc_split: BASE_W out of range");
   end

   // count sits in the low field, base occupies every bit above it
   assign count = desc[CNT_W-1:0];
   assign base  = desc[DESC_W-1:CNT_W];
   assign empty = (count == '0);

endmodule

// File: rtl/bag_mem.sv
module bag_mem #(
   parameter int DATA_W = 32,
   parameter int MEM_AW = 8,
   parameter int ADDR_W = 18,
   localparam int DEPTH = 1 << MEM_AW
) (
   input  logic              clk,
   input  logic              wr_en,
   input  logic [MEM_AW-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data
);

   if (MEM_AW < 1 || MEM_AW > 12) begin : g_bad_aw
      $error("bag_mem: MEM_AW out of range");
   end
   if (DATA_W < 1) begin : g_bad_dw
      $error("bag_mem: DATA_W out of range");
   end

   logic [DATA_W-1:0] store [DEPTH];
   logic [MEM_AW-1:0] rd_idx;

   // fold the wide address onto the array: modulo depth
   if (MEM_AW < ADDR_W) begin : g_trunc
      assign rd_idx = rd_addr[MEM_AW-1:0];
   end else if (MEM_AW == ADDR_W) begin : g_same
      assign rd_idx = rd_addr;
   end else begin : g_widen
      assign rd_idx = {{(MEM_AW-ADDR_W){1'b0}}, rd_addr};
   end

   always_ff @(posedge clk) begin
      if (wr_en) store[wr_addr] <= wr_data;
      if (rd_en) rd_data <= store[rd_idx];
   end

endmodule

// File: rtl/bag_seq.sv
module bag_seq
   import bag_pkg::*;
#(
   parameter int CNT_W  = 6,
   parameter int ADDR_W = 18
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              start,
   input  logic [ADDR_W-1:0] start_base,
   input  logic [CNT_W-1:0]  start_cnt,
   output logic              busy,
   output logic              rd_en,
   output logic [ADDR_W-1:0] rd_addr,
   output logic              ins_valid,
   input  logic              ins_ready,
   output logic [ADDR_W-1:0] ins_addr,
   output logic              bag_done
);

   seq_state_t        state;
   logic [CNT_W-1:0]  left;
   logic [ADDR_W-1:0] next_addr;
   logic              slot_free;
   logic              issue;
   logic              taken;

   assign busy      = (state != SEQ_IDLE);
   assign taken     = ins_valid & ins_ready;
   assign slot_free = ~ins_valid | ins_ready;
   assign issue     = (state == SEQ_RUN) & slot_free;
   assign rd_en     = issue;
   assign rd_addr   = next_addr;

   always_ff @(posedge clk) begin
      if (rst) begin
         state     <= SEQ_IDLE;
         left      <= '0;
         next_addr <= '0;
         ins_valid <= 1'b0;
         ins_addr  <= '0;
         bag_done  <= 1'b0;
      end else begin
         bag_done <= 1'b0;
         unique case (state)
            SEQ_IDLE: begin
               if (start && start_cnt != '0) begin
                  state     <= SEQ_RUN;
                  left      <= start_cnt;
                  next_addr <= start_base;
               end
            end
            SEQ_RUN: begin
               if (issue && left == CNT_W'(1)) state <= SEQ_DRAIN;
            end
            SEQ_DRAIN: begin
               if (taken) begin
                  state    <= SEQ_IDLE;
                  bag_done <= 1'b1;
               end
            end
            default: state <= SEQ_IDLE;
         endcase

         if (issue) begin
            ins_valid <= 1'b1;
            ins_addr  <= next_addr;
            next_addr <= next_addr + 1'b1;
            left      <= left - 1'b1;
         end else if (taken) begin
            ins_valid <= 1'b0;
         end
      end
   end

   AST_HOLD_STALL: assert property (@(posedge clk) disable iff (rst)
      ins_valid && !ins_ready |=> ins_valid && $stable(ins_addr)) else $error("stall hold"); // R6
   AST_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
      taken |=> !ins_valid || ins_addr == ADDR_W'($past(ins_addr) + 1'b1)) else $error("addr step"); // R2
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
      bag_done |=> !bag_done) else $error("done pulse"); // R8
   AST_DONE_AFTER_TAKE: assert property (@(posedge clk) disable iff (rst)
      bag_done |-> $past(taken) && !busy) else $error("done cause"); // R8

endmodule

// File: rtl/bag_dispatch.sv
module bag_dispatch #(
   parameter int DATA_W = 32,
   parameter int CNT_W  = 6,
   parameter int BASE_W = 18,
   parameter int MEM_AW = 8,
   localparam int DESC_W = BASE_W + CNT_W
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              desc_valid,
   output logic              desc_ready,
   input  logic [DESC_W-1:0] desc_word,
   input  logic              wr_en,
   input  logic [MEM_AW-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic              ins_valid,
   input  logic              ins_ready,
   output logic [DATA_W-1:0] ins_word,
   output logic [BASE_W-1:0] ins_addr,
   output logic              bag_done
);

   logic [BASE_W-1:0] d_base;
   logic [CNT_W-1:0]  d_cnt;
   logic              d_empty;
   logic              accept;
   logic              busy;
   logic              rd_en;
   logic [BASE_W-1:0] rd_addr;

   bag_desc_split #(.CNT_W(CNT_W), .BASE_W(BASE_W)) u_split (
      .desc  (desc_word),
      .base  (d_base),
      .count (d_cnt),
      .empty (d_empty)
   );

   assign desc_ready = ~busy;
   assign accept     = desc_valid & desc_ready;

   bag_seq #(.CNT_W(CNT_W), .ADDR_W(BASE_W)) u_seq (
      .clk        (clk),
      .rst        (rst),
      .start      (accept),
      .start_base (d_base),
      .start_cnt  (d_cnt),
      .busy       (busy),
      .rd_en      (rd_en),
      .rd_addr    (rd_addr),
      .ins_valid  (ins_valid),
      .ins_ready  (ins_ready),
      .ins_addr   (ins_addr),
      .bag_done   (bag_done)
   );

   bag_mem #(.DATA_W(DATA_W), .MEM_AW(MEM_AW), .ADDR_W(BASE_W)) u_mem (
      .clk     (clk),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .rd_en   (rd_en),
      .rd_addr (rd_addr),
      .rd_data (ins_word)
   );

   AST_EMPTY_IDLE: assert property (@(posedge clk) disable iff (rst)
      accept && d_empty |=> desc_ready && !ins_valid) else $error("empty bag"); // R4
   AST_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (rst)
      ins_valid |-> !desc_ready) else $error("ready while streaming"); // R5
   AST_WORD_STALL: assert property (@(posedge clk) disable iff (rst)
      ins_valid && !ins_ready |=> $stable(ins_word)) else $error("word moved"); // R6
   AST_FIRST_LATENCY: assert property (@(posedge clk) disable iff (rst)
      accept && !d_empty |=> !ins_valid) else $error("early word"); // R10

endmodule

// File: tb/bag_dispatch_tb.sv
module bag_dispatch_tb;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        desc_valid = 1'b0;
   logic        desc_ready;
   logic [23:0] desc_word = '0;
   logic        wr_en = 1'b0;
   logic [7:0]  wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic        ins_valid;
   logic        ins_ready = 1'b0;
   logic [31:0] ins_word;
   logic [17:0] ins_addr;
   logic        bag_done;

   int checks = 0;
   int errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   bag_dispatch u_dut (
      .clk(clk), .rst(rst), .desc_valid(desc_valid), .desc_ready(desc_ready),
      .desc_word(desc_word), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .ins_valid(ins_valid), .ins_ready(ins_ready), .ins_word(ins_word),
      .ins_addr(ins_addr), .bag_done(bag_done)
   );

   // {base[17:0], count[5:0], ready pattern[7:0]}
   localparam logic [31:0] VEC [6] = '{
      {18'd5,       6'd4,  8'hFF},
      {18'd100,     6'd1,  8'hFF},
      {18'd250,     6'd10, 8'hFF},
      {18'h3FFFE,   6'd5,  8'b1011_0010},
      {18'd0,       6'd63, 8'b0101_0101},
      {18'd40,      6'd7,  8'b0001_1111}
   };

   function automatic logic [31:0] mpat(input int i);
      return {8'hC3, 8'(i), 16'(i * 37 + 11)};
   endfunction

   task automatic chk(input bit ok, input string req, input logic [63:0] act,
                      input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic run_bag(input logic [17:0] base, input logic [5:0] cnt,
                          input logic [7:0] pat);
      int took = 0;
      int it = 0;
      int first = -1;
      logic [17:0] ea;
      @(negedge clk);
      desc_word  = {base, cnt};
      desc_valid = 1'b1;
      ins_ready  = 1'b0;
      @(posedge clk);
      @(negedge clk);
      desc_word  = {18'h2AAAA, 6'd9};
      desc_valid = (cnt > 1);
      chk(desc_ready == 1'b0, "R5 ready low while busy", 64'(desc_ready), 64'd0);
      while (took < int'(cnt) && it < 600) begin
         ins_ready = pat[it % 8];
         if (ins_valid && first < 0) first = it;
         if (ins_valid && ins_ready) begin
            ea = base + 18'(took);
            chk(ins_addr == ea, "R2 address tag", 64'(ins_addr), 64'(ea));
            chk(ins_word == mpat(int'(ea[7:0])), "R3/R7 word data",
                64'(ins_word), 64'(mpat(int'(ea[7:0]))));
            chk(bag_done == 1'b0, "R8 no early done", 64'(bag_done), 64'd0);
            if (took == int'(cnt) - 1) desc_valid = 1'b0;
            took++;
         end
         it++;
         @(negedge clk);
      end
      ins_ready = 1'b0;
      chk(first == 1, "R10 first word latency", 64'(first), 64'd1);
      if (pat == 8'hFF)
         chk(it == int'(cnt) + 1, "R10 one word per cycle", 64'(it), 64'(int'(cnt) + 1));
      chk(bag_done == 1'b1, "R8 done pulse", 64'(bag_done), 64'd1);
      chk(desc_ready == 1'b1, "R8 ready with done", 64'(desc_ready), 64'd1);
      @(negedge clk);
      chk(bag_done == 1'b0, "R8 done one cycle", 64'(bag_done), 64'd0);
      for (int k = 0; k < 3; k++) begin
         chk(ins_valid == 1'b0, "R5 junk descriptor ignored", 64'(ins_valid), 64'd0);
         @(negedge clk);
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R9 reset state
      chk(ins_valid == 1'b0, "R9 reset ins_valid", 64'(ins_valid), 64'd0);
      chk(bag_done == 1'b0, "R9 reset done", 64'(bag_done), 64'd0);
      chk(desc_ready == 1'b1, "R9 reset ready", 64'(desc_ready), 64'd1);
      rst = 1'b0;
      for (int i = 0; i < 256; i++) begin
         wr_en = 1'b1; wr_addr = 8'(i); wr_data = mpat(i);
         @(negedge clk);
      end
      wr_en = 1'b0;

      // R1 field split, R2/R3 ordering, R6 stalls, R7 wrap in the table
      for (int v = 0; v < 6; v++) begin
         run_bag(VEC[v][31:14], VEC[v][13:8], VEC[v][7:0]);
      end

      // R4 zero count
      @(negedge clk);
      desc_word = {18'd12, 6'd0}; desc_valid = 1'b1; ins_ready = 1'b1;
      @(negedge clk);
      desc_valid = 1'b0;
      for (int k = 0; k < 5; k++) begin
         chk(ins_valid == 1'b0, "R4 zero count no word", 64'(ins_valid), 64'd0);
         chk(bag_done == 1'b0, "R4 zero count no done", 64'(bag_done), 64'd0);
         chk(desc_ready == 1'b1, "R4 zero count ready", 64'(desc_ready), 64'd1);
         @(negedge clk);
      end

      // R9 reset mid-bag
      desc_word = {18'd30, 6'd20}; desc_valid = 1'b1; ins_ready = 1'b1;
      @(negedge clk);
      desc_valid = 1'b0;
      repeat (4) @(negedge clk);
      chk(ins_valid == 1'b1, "R9 bag running before reset", 64'(ins_valid), 64'd1);
      rst = 1'b1; ins_ready = 1'b0;
      @(negedge clk);
      chk(ins_valid == 1'b0, "R9 mid-bag reset valid", 64'(ins_valid), 64'd0);
      chk(desc_ready == 1'b1, "R9 mid-bag reset ready", 64'(desc_ready), 64'd1);
      rst = 1'b0;
      @(negedge clk);
      chk(ins_valid == 1'b0, "R9 after reset valid", 64'(ins_valid), 64'd0);
      chk(bag_done == 1'b0, "R9 after reset done", 64'(bag_done), 64'd0);
      run_bag(18'd77, 6'd3, 8'hFF);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule